// File: doc/BRIEF.md
# Two-Tier Prioritized Interrupt Controller

This block gathers single-cycle event pulses from a set of interrupt sources and keeps one pending flag per source. Each source feeds a vector, and several sources may share a vector. Each vector belongs to one of eight interrupt levels. A level may own several vectors, one vector, or none. The controller picks one vector to present to the processor in two stages. First it chooses a level, using a software-written rank table. Then, inside that level, it chooses a vector by a fixed hardware order.

The processor sees a request line and a registered vector number. It answers with an acknowledge pulse. Each source has its own clearing rule, fixed at build time. On acknowledge, hardware clears the pending flag of an auto-clear source. A manual-clear source keeps its flag set until software clears it with a write. A small write-only register port sets the rank table, the per-level enables and the global enable, and accepts write-one-to-clear requests for pending flags.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, these are all zero: every pending flag, the request, the vector output, the global enable and all level enables. The rank table holds the identity order, so rank r holds level r.
- R2: An event pulse on source s sets pending flag s at the next clock edge. This happens whatever the global enable and level enables are set to.
- R3: A write to address 3 clears every pending flag whose data bit is 1. If a source pulses in the same cycle as its clear, the event wins and the flag stays set.
- R4: A request is raised only when all three of these hold: the global enable is 1 (address 2, bit 0), at least one level has its enable bit set (address 1, bit l for level l), and that level has a pending vector.
- R5: Level choice follows the rank table at address 0. Rank r is data bits [3r+2:3r] and holds a level number, and rank 0 is the highest priority. The level number itself carries no priority. A level that appears in no rank never wins.
- R6: Source s maps to vector s for s below 19, and sources 19 and 20 share vector 19. Vector v belongs to level v/3, so level 7 has no vectors. Within the winning level, the lowest-numbered pending vector wins.
- R7: When the controller is idle with an eligible request, the request line rises at the next clock edge. The vector number is captured at that same edge. It then holds steady for as long as the request stays high.
- R8: An acknowledge while the request is high has three effects at that edge. It drops the request. It clears the pending flags of auto-clear sources that map to the presented vector; a source is auto-clear when its index is even. Manual-clear sources stay pending. An acknowledge while the request is low has no effect.
- R9: If the global enable is 0 while a request is high, the request drops at the next edge.
- R10: The vector number port is 7 bits wide, so it can name up to 128 vectors. Unused upper bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | 21 | One-cycle event pulse per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 rank table, 1 level enables, 2 global enable, 3 pending clear |
| reg_wdata | input | 24 | Register write data |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | 7 | Vector number of the presented request |
| irq_ack | input | 1 | Acknowledge pulse from the processor |
| src_pend | output | 21 | Pending flag of each source |

## Verification
The bench targets the shared vector 19, which carries one manual-clear source and one auto-clear source. A design that cleared by vector instead of by source would lose the manual flag on acknowledge, and the bench would not see the re-request it expects. Other directed cases cover:
- a rank table that puts low level numbers last, or leaves some levels out, which exposes any fallback to level-number order;
- a clear and an event on the same source in one cycle, where a design that lets the clear win would drop an event;
- an acknowledge while no request is raised, which must change nothing;
- dropping the global enable during a request, which a design that latched the request would ignore.

A long randomized stretch then changes ranks, enables, events and acknowledge timing. It would catch a vector that changes in the middle of a request, or a winner taken from stale pending state.

// File: rtl/irqc_pkg.sv
// Package: shared constants and the fixed source/vector/level maps.
// Assumes at most eight levels and a 3-bit level index.
package irqc_pkg;

    localparam int LVL_N = 8;
    localparam int LVL_W = 3;
    localparam int RANK_W = LVL_N * LVL_W;

    // Source-to-vector map: the last sources fold onto vector n_vec-2.
    function automatic int vec_of_src(input int s, input int n_vec);
        return (s < n_vec - 2) ? s : n_vec - 2;
    endfunction

    // Vector-to-level map: consecutive groups of per_lvl vectors per level.
    function automatic int lvl_of_vec(input int v, input int per_lvl);
        return v / per_lvl;
    endfunction

    // Identity rank table: rank r holds level r.
    function automatic logic [RANK_W-1:0] rank_identity();
        logic [RANK_W-1:0] t;
        t = '0;
        for (int r = 0; r < LVL_N; r++) begin
            t[r*LVL_W +: LVL_W] = LVL_W'(r);
        end
        return t;
    endfunction

endpackage

// File: rtl/irqc_pend.sv
// Pending flag bank: one flag per source. An event sets its flag. A software
// clear or an acknowledge of the source's vector clears it, but the acknowledge
// only clears sources built as auto-clear. A new event wins over any clear.
module irqc_pend #(
    parameter int N_SRC = 21,
    parameter int N_VEC = 21,
    parameter int VEC_W = 7,
    parameter logic [N_SRC-1:0] AUTO_CLR = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt,
    input  logic [N_SRC-1:0] sw_clr,
    input  logic             ack_fire,
    input  logic [VEC_W-1:0] ack_vec,
    output logic [N_SRC-1:0] pend
);

    logic [N_SRC-1:0] hw_clr;

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        if (AUTO_CLR[s]) begin : g_auto
            // Hardware clear when the presented vector is this source's vector.
            assign hw_clr[s] = ack_fire &&
                (ack_vec == VEC_W'(irqc_pkg::vec_of_src(s, N_VEC)));
        end else begin : g_manual
            assign hw_clr[s] = 1'b0;
        end
    end

    // Flag update: set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= evt | (pend & ~sw_clr & ~hw_clr);
        end
    end

endmodule

// File: rtl/irqc_vec_map.sv
// Folds source flags into per-vector pending bits, then per-vector bits into
// per-level pending bits, following the package maps.
module irqc_vec_map #(
    parameter int N_SRC = 21,
    parameter int N_VEC = 21,
    parameter int VEC_PER_LVL = 3
) (
    input  logic [N_SRC-1:0]            pend,
    output logic [N_VEC-1:0]            vec_pend,
    output logic [irqc_pkg::LVL_N-1:0]  lvl_pend
);

    // Source-to-vector OR reduction.
    always_comb begin
        vec_pend = '0;
        for (int s = 0; s < N_SRC; s++) begin
            vec_pend[irqc_pkg::vec_of_src(s, N_VEC)] =
                vec_pend[irqc_pkg::vec_of_src(s, N_VEC)] | pend[s];
        end
    end

    // Vector-to-level OR reduction.
    always_comb begin
        lvl_pend = '0;
        for (int v = 0; v < N_VEC; v++) begin
            lvl_pend[irqc_pkg::lvl_of_vec(v, VEC_PER_LVL)] =
                lvl_pend[irqc_pkg::lvl_of_vec(v, VEC_PER_LVL)] | vec_pend[v];
        end
    end

endmodule

// File: rtl/irqc_lvl_arb.sv
// Level arbiter: walks the rank table from rank 0 (highest) and returns the
// first level that is eligible. Repeated entries are allowed, and a level that
// is listed nowhere never wins.
module irqc_lvl_arb (
    input  logic [irqc_pkg::RANK_W-1:0] rank_tbl,
    input  logic [irqc_pkg::LVL_N-1:0]  elig,
    output logic                        found,
    output logic [irqc_pkg::LVL_W-1:0]  win_lvl
);

    // Scan the ranks from lowest priority upward, so rank 0 overrides the rest.
    always_comb begin
        found   = 1'b0;
        win_lvl = '0;
        for (int r = irqc_pkg::LVL_N - 1; r >= 0; r--) begin
            if (elig[rank_tbl[r*irqc_pkg::LVL_W +: irqc_pkg::LVL_W]]) begin
                found   = 1'b1;
                win_lvl = rank_tbl[r*irqc_pkg::LVL_W +: irqc_pkg::LVL_W];
            end
        end
    end

endmodule

// File: rtl/irqc_vec_pick.sv
// Fixed in-level order: the lowest-numbered pending vector that belongs to the
// winning level. Assumes the level's vectors are set by the package map.
module irqc_vec_pick #(
    parameter int N_VEC = 21,
    parameter int VEC_W = 7,
    parameter int VEC_PER_LVL = 3
) (
    input  logic [N_VEC-1:0]            vec_pend,
    input  logic [irqc_pkg::LVL_W-1:0]  win_lvl,
    output logic [VEC_W-1:0]            win_vec
);

    // Descending scan, so the lowest index is assigned last and wins.
    always_comb begin
        win_vec = '0;
        for (int v = N_VEC - 1; v >= 0; v--) begin
            if (vec_pend[v] &&
                (win_lvl == irqc_pkg::LVL_W'(irqc_pkg::lvl_of_vec(v, VEC_PER_LVL)))) begin
                win_vec = VEC_W'(v);
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the two-tier interrupt controller. It holds the register file (rank
// table, level enables, global enable, pending clear) and the request register,
// and wires up the pending bank and the two arbitration stages.
// Assumes src_evt is already one cycle wide per event, and irq_ack is a pulse.
module prio_irq_ctrl #(
    parameter int N_SRC = 21,
    parameter int N_VEC = 21,
    parameter int VEC_PER_LVL = 3,
    parameter int VEC_W = 7,
    parameter int REG_W = 24,
    parameter logic [N_SRC-1:0] AUTO_CLR = 21'h15_5555
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_evt,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    input  logic             irq_ack,
    output logic [N_SRC-1:0] src_pend
);

    localparam int LVL_N = irqc_pkg::LVL_N;
    localparam int LVL_W = irqc_pkg::LVL_W;
    localparam int RANK_W = irqc_pkg::RANK_W;
    localparam logic [1:0] A_RANK = 2'd0;
    localparam logic [1:0] A_LVLEN = 2'd1;
    localparam logic [1:0] A_GIE = 2'd2;
    localparam logic [1:0] A_CLR = 2'd3;

    logic [RANK_W-1:0] rank_q;
    logic [LVL_N-1:0]  lvl_en_q;
    logic              gie_q;
    logic              req_q;
    logic [VEC_W-1:0]  vec_q;
    logic [N_SRC-1:0]  sw_clr;
    logic              ack_fire;
    logic [N_VEC-1:0]  vec_pend;
    logic [LVL_N-1:0]  lvl_pend;
    logic [LVL_N-1:0]  elig;
    logic              found;
    logic [LVL_W-1:0]  win_lvl;
    logic [VEC_W-1:0]  win_vec;

    // Software clear strobe, one bit per source.
    always_comb begin
        sw_clr = '0;
        if (reg_wr && (reg_addr == A_CLR)) begin
            sw_clr = reg_wdata[N_SRC-1:0];
        end
    end

    assign ack_fire = req_q && irq_ack;
    assign elig     = lvl_pend & lvl_en_q;

    // Register file writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rank_q   <= irqc_pkg::rank_identity();
            lvl_en_q <= '0;
            gie_q    <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_RANK:  rank_q   <= reg_wdata[RANK_W-1:0];
                A_LVLEN: lvl_en_q <= reg_wdata[LVL_N-1:0];
                A_GIE:   gie_q    <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    // Request register: capture when idle, hold until acknowledge or disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            vec_q <= '0;
        end else if (req_q) begin
            if (irq_ack || !gie_q) begin
                req_q <= 1'b0;
            end
        end else if (gie_q && found) begin
            req_q <= 1'b1;
            vec_q <= win_vec;
        end
    end

    irqc_pend #(
        .N_SRC(N_SRC), .N_VEC(N_VEC), .VEC_W(VEC_W), .AUTO_CLR(AUTO_CLR)
    ) u_pend (
        .clk(clk), .rst_n(rst_n), .evt(src_evt), .sw_clr(sw_clr),
        .ack_fire(ack_fire), .ack_vec(vec_q), .pend(src_pend)
    );

    irqc_vec_map #(
        .N_SRC(N_SRC), .N_VEC(N_VEC), .VEC_PER_LVL(VEC_PER_LVL)
    ) u_map (
        .pend(src_pend), .vec_pend(vec_pend), .lvl_pend(lvl_pend)
    );

    irqc_lvl_arb u_lvl (
        .rank_tbl(rank_q), .elig(elig), .found(found), .win_lvl(win_lvl)
    );

    irqc_vec_pick #(
        .N_VEC(N_VEC), .VEC_W(VEC_W), .VEC_PER_LVL(VEC_PER_LVL)
    ) u_pick (
        .vec_pend(vec_pend), .win_lvl(win_lvl), .win_vec(win_vec)
    );

    assign irq_req = req_q;
    assign irq_vec = vec_q;

endmodule

// File: rtl/irqc_chk.sv
// Checker for prio_irq_ctrl, attached with the bind below.
module irqc_chk #(
    parameter int N_SRC = 21,
    parameter int N_VEC = 21,
    parameter int VEC_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_evt,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input logic             irq_ack,
    input logic [N_SRC-1:0] src_pend,
    input logic             gie
);

    // R2: every pulsed source is pending one edge later.
    a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt != '0) |=> ((src_pend & $past(src_evt)) == $past(src_evt)));

    // R7: an unanswered, enabled request holds its vector.
    a_r7_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack && gie) |=> (irq_req && $stable(irq_vec)));

    // R8: an acknowledged request is dropped.
    a_r8_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req);

    // R9: a disabled controller withdraws its request.
    a_r9_gie_withdraws: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !gie) |=> !irq_req);

    // R4: a request only rises while the global enable is set.
    a_r4_rise_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(gie));

    // R10: a presented vector names an existing vector.
    a_r10_vec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (int'(irq_vec) < N_VEC));

endmodule

bind prio_irq_ctrl irqc_chk #(.N_SRC(N_SRC), .N_VEC(N_VEC), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_ack(irq_ack), .src_pend(src_pend), .gie(gie_q)
);

// File: tb/sim_prio_irq_ctrl.sv
// Bench: a behavioural model advanced once per clock and compared every cycle.
module sim_prio_irq_ctrl;

    localparam int NS = 21;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NS-1:0] src_evt;
    logic          reg_wr;
    logic [1:0]    reg_addr;
    logic [23:0]   reg_wdata;
    logic          irq_req;
    logic [6:0]    irq_vec;
    logic          irq_ack;
    logic [NS-1:0] src_pend;

    always #4 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_ack(irq_ack), .src_pend(src_pend)
    );

    int    m_pend[NS];
    int    m_rank[8];
    int    m_en, m_gie, m_req, m_vec;
    int    checks = 0;
    int    fails = 0;
    string tag = "R1";
    bit    done = 0;

    function automatic int vof(int s); return (s == 20) ? 19 : s; endfunction
    function automatic int lof(int v); return v / 3; endfunction
    function automatic bit is_auto(int s); return (s % 2) == 0; endfunction

    task automatic model_step();
        int np[NS];
        int lvl_has[8];
        int win_v, nreq, nvec;
        if (!rst_n) begin
            foreach (m_pend[i]) m_pend[i] = 0;
            for (int r = 0; r < 8; r++) m_rank[r] = r;
            m_en = 0; m_gie = 0; m_req = 0; m_vec = 0;
            return;
        end
        for (int l = 0; l < 8; l++) lvl_has[l] = 0;
        for (int s = 0; s < NS; s++) if (m_pend[s] != 0) lvl_has[lof(vof(s))] = 1;
        win_v = -1;
        for (int r = 0; r < 8 && win_v < 0; r++) begin
            int l = m_rank[r];
            if (lvl_has[l] != 0 && m_en[l]) begin
                for (int v = 0; v < 21 && win_v < 0; v++)
                    for (int s = 0; s < NS; s++)
                        if (m_pend[s] != 0 && vof(s) == v && lof(v) == l) win_v = v;
            end
        end
        nreq = m_req; nvec = m_vec;
        if (m_req != 0) begin
            if (irq_ack || m_gie == 0) nreq = 0;
        end else if (m_gie != 0 && win_v >= 0) begin
            nreq = 1; nvec = win_v;
        end
        for (int s = 0; s < NS; s++) begin
            bit clr = 0;
            if (reg_wr && reg_addr == 2'd3 && reg_wdata[s]) clr = 1;
            if (m_req != 0 && irq_ack && is_auto(s) && vof(s) == m_vec) clr = 1;
            np[s] = (src_evt[s] || (m_pend[s] != 0 && !clr)) ? 1 : 0;
        end
        if (reg_wr) begin
            case (reg_addr)
                2'd0: for (int r = 0; r < 8; r++) m_rank[r] = int'(reg_wdata[r*3 +: 3]);
                2'd1: m_en = int'(reg_wdata[7:0]);
                2'd2: m_gie = int'(reg_wdata[0]);
                default: ;
            endcase
        end
        m_pend = np; m_req = nreq; m_vec = nvec;
    endtask

    task automatic tick();
        logic [NS-1:0] ep;
        @(posedge clk);
        @(negedge clk);
        model_step();
        for (int s = 0; s < NS; s++) ep[s] = (m_pend[s] != 0);
        checks++;
        if (irq_req !== m_req[0] || irq_vec !== m_vec[6:0] || src_pend !== ep) begin
            fails++;
            $display("FAIL %s: req=%0b vec=%0d pend=%h expected req=%0d vec=%0d pend=%h",
                     tag, irq_req, irq_vec, src_pend, m_req, m_vec, ep);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [23:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic fire(input logic [NS-1:0] m);
        src_evt = m;
        tick();
        src_evt = '0;
    endtask

    task automatic ack();
        irq_ack = 1;
        tick();
        irq_ack = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R7: watchdog expired, actual running expected finished");
            finish_run();
        end
    end

    initial begin
        rst_n = 0; src_evt = '0; reg_wr = 0; reg_addr = '0; reg_wdata = '0; irq_ack = 0;
        tag = "R1";
        repeat (3) tick();
        rst_n = 1;
        tick();

        tag = "R2";  // events latch while everything is disabled
        fire(21'h00_0011);
        fire(21'h10_0000);
        tick();

        tag = "R3";  // clear, then clear colliding with a new event
        wr(2'd3, 24'h00_0001);
        reg_wr = 1; reg_addr = 2'd3; reg_wdata = 24'h10_0010; src_evt = 21'h00_0010;
        tick();
        reg_wr = 0; src_evt = '0;
        tick();

        tag = "R4";  // global on, levels off: no request
        wr(2'd2, 24'h1);
        repeat (2) tick();
        wr(2'd1, 24'hFF);
        tick(); tick();

        tag = "R8";  // ack vector 4 (auto source 4): cleared
        ack();
        repeat (2) tick();

        tag = "R5";  // reversed ranks: level 6 beats level 0
        wr(2'd3, 24'h1F_FFFF);
        repeat (2) tick();
        wr(2'd0, {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd7, 3'd6});
        fire(21'h04_0001);  // sources 0 and 18
        tick(); tick();
        ack();
        tick(); tick();

        tag = "R6";  // level 1 holds vectors 3,4,5: lowest pending wins
        wr(2'd3, 24'h1F_FFFF);
        wr(2'd0, {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd0, 3'd1});
        fire(21'h00_0030);
        tick(); tick();
        ack();
        tick(); tick();
        ack();
        tick();

        tag = "R8";  // shared vector 19: auto source 20 cleared, manual 19 kept
        wr(2'd3, 24'h1F_FFFF);
        wr(2'd0, {3'd7, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0, 3'd6});
        fire(21'h18_0000);
        tick(); tick();
        ack();
        tick(); tick();
        ack();
        tick(); tick();
        irq_ack = 1; tick(); irq_ack = 0;  // stray ack when idle if request dropped
        wr(2'd3, 24'h1F_FFFF);
        tick();
        irq_ack = 1; tick(); tick(); irq_ack = 0;  // ack with no request: no effect

        tag = "R9";  // disabling withdraws the request
        fire(21'h00_0100);
        tick(); tick();
        wr(2'd2, 24'h0);
        tick(); tick();
        wr(2'd2, 24'h1);
        tick(); tick();

        tag = "R5";  // level absent from the table never wins
        wr(2'd3, 24'h1F_FFFF);
        wr(2'd0, {3'd1, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1});
        fire(21'h00_0001);
        tick(); tick(); tick();

        tag = "R7";  // randomized ranks, enables, events and ack timing
        for (int i = 0; i < 4000; i++) begin
            int k = int'($urandom_range(0, 19));
            src_evt = NS'($urandom & $urandom & $urandom);
            irq_ack = ($urandom_range(0, 3) == 0);
            if (k == 0) begin
                reg_wr = 1; reg_addr = 2'($urandom_range(0, 3)); reg_wdata = 24'($urandom);
                if (reg_addr == 2'd2 && $urandom_range(0, 3) != 0) reg_wdata[0] = 1'b1;
            end
            tick();
            reg_wr = 0; src_evt = '0; irq_ack = 0;
        end

        tag = "R10";  // presented vector stays within the 7-bit vector field
        wr(2'd3, 24'h1F_FFFF);
        wr(2'd0, 24'hFAC688);
        wr(2'd1, 24'hFF);
        wr(2'd2, 24'h1);
        fire(21'h10_0000);
        tick(); tick();
        ack();
        tick();

        finish_run();
    end

endmodule